// File: doc/BRIEF.md
# Programmable delay trigger timer

The block counts divided clock ticks over a programmable period and raises one request per period at a programmable count inside that period. The request point is set apart from the period length, so the trigger frequency stays fixed while the trigger phase moves. A request is delivered in one of two ways: as a sticky interrupt flag, or as a single-cycle DMA request pulse.

Software programs the block through a small write port and a combinational read port. The tick rate is the input clock divided by a power-of-two prescale times a multiplier. Period and delay writes go to shadow copies. The copies take effect at once while the timer is stopped. While it runs, they take effect at the next counter wrap, and only after software arms the transfer.

Register map (word addresses): 0 = control, 1 = period (modulus), 2 = delay, 3 = count (read only). Control bits: 0 run, 3:1 prescale exponent n (divide by 2^n), 5:4 multiplier code (0 = x1, 1 = x10, 2 = x20, 3 = x40), 6 request enable, 7 DMA mode, 8 load arm (write 1 to arm; reads 1 while pending), 9 flag (reads the sticky flag; writing 1 clears it).

Top module: `dly_trig_timer`

## Requirements
- R1: After reset, irq_o and dma_req_o are low and all four registers read zero.
- R2: A tick occurs every F input clocks, with F = 2^n times the multiplier selected by code 0..3 as x1, x10, x20, x40.
- R3: The count advances by one per tick and returns to zero on the tick after it equals the period value, so requests repeat every F*(period+1) clocks.
- R4: A match occurs on a tick in which the count equals the delay. After the clock edge that sets run, the first match falls F*(delay+1) clocks later.
- R5: A delay value larger than the period value never produces a request.
- R6: With request enable (bit 6) clear, matches set no flag and produce no DMA pulse.
- R7: With DMA mode (bit 7) set, each match drives dma_req_o high for exactly one clock, and the flag stays clear.
- R8: With DMA mode clear, a match sets a sticky flag shown on irq_o and in control bit 9. Stopping the timer leaves the flag set. Writing 1 to bit 9 clears it.
- R9: Reads of period and delay return the values in force, not a pending shadow write.
- R10: While running, an armed load moves both shadows into force at the next wrap. Bit 8 reads 1 until that wrap and 0 after it.
- R11: While stopped, the count is held at zero and period and delay writes are in force at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write word address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read word address |
| rd_data_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Sticky interrupt flag |
| dma_req_o | output | 1 | Single-cycle DMA request |

## Verification
A wrong divider or count state moves the request pulses. The first misplaced pulse appears within one period of the enabling write, and the scoreboard, which holds each expected pulse cycle, flags it to the exact clock. A shadow transfer that fires early or late shows on the delay read-back and the load-arm bit in the cycle after the wrap, and it shifts the next request by the change in delay. A flag that fails to hold or to clear shows on irq_o in the cycle after the triggering write.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  localparam int unsigned PRE_W = 3;
  localparam int unsigned MUL_W = 2;
  localparam int unsigned MAX_MUL = 40;

  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_PERIOD = 2'd1;
  localparam logic [1:0] A_DELAY  = 2'd2;
  localparam logic [1:0] A_COUNT  = 2'd3;

  localparam int unsigned B_RUN  = 0;
  localparam int unsigned B_PRE  = 1;
  localparam int unsigned B_MUL  = 4;
  localparam int unsigned B_REN  = 6;
  localparam int unsigned B_DMA  = 7;
  localparam int unsigned B_ARM  = 8;
  localparam int unsigned B_FLAG = 9;

  typedef struct packed {
    logic             run;
    logic [PRE_W-1:0] pre;
    logic [MUL_W-1:0] mul;
    logic             req_en;
    logic             dma_mode;
  } ctrl_t;

  function automatic logic [5:0] mul_factor(input logic [MUL_W-1:0] sel);
    case (sel)
      2'd0:    return 6'd1;
      2'd1:    return 6'd10;
      2'd2:    return 6'd20;
      default: return 6'd40;
    endcase
  endfunction
endpackage

// File: rtl/dtt_regs.sv
module dtt_regs
  import dtt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  input  logic [CNT_W-1:0]  mod_act_i,
  input  logic [CNT_W-1:0]  dly_act_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              arm_pend_i,
  input  logic              flag_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  mod_shd_o,
  output logic [CNT_W-1:0]  dly_shd_o,
  output logic              arm_set_o,
  output logic              flag_clr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic ctrl_wr;
  assign ctrl_wr    = wr_en_i && (wr_addr_i == A_CTRL);
  assign arm_set_o  = ctrl_wr && wr_data_i[B_ARM];
  assign flag_clr_o = ctrl_wr && wr_data_i[B_FLAG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= '0;
      mod_shd_o <= '0;
      dly_shd_o <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_CTRL: begin
          ctrl_o.run      <= wr_data_i[B_RUN];
          ctrl_o.pre      <= wr_data_i[B_PRE +: PRE_W];
          ctrl_o.mul      <= wr_data_i[B_MUL +: MUL_W];
          ctrl_o.req_en   <= wr_data_i[B_REN];
          ctrl_o.dma_mode <= wr_data_i[B_DMA];
        end
        A_PERIOD: mod_shd_o <= wr_data_i[CNT_W-1:0];
        A_DELAY:  dly_shd_o <= wr_data_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_CTRL: begin
        rd_data_o[B_RUN]         = ctrl_o.run;
        rd_data_o[B_PRE +: PRE_W] = ctrl_o.pre;
        rd_data_o[B_MUL +: MUL_W] = ctrl_o.mul;
        rd_data_o[B_REN]         = ctrl_o.req_en;
        rd_data_o[B_DMA]         = ctrl_o.dma_mode;
        rd_data_o[B_ARM]         = arm_pend_i;
        rd_data_o[B_FLAG]        = flag_i;
      end
      A_PERIOD: rd_data_o = DATA_W'(mod_act_i);
      A_DELAY:  rd_data_o = DATA_W'(dly_act_i);
      default:  rd_data_o = DATA_W'(cnt_i);
    endcase
  end
endmodule

// File: rtl/dtt_divider.sv
module dtt_divider
  import dtt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [MUL_W-1:0] mul_i,
  output logic             tick_o
);
  localparam int unsigned MAX_DIV = (1 << ((1 << PRE_W) - 1)) * MAX_MUL;
  localparam int unsigned DIV_W   = $clog2(MAX_DIV + 1);

  logic [DIV_W-1:0] factor, div_q;
  logic             last;

  assign factor = DIV_W'(mul_factor(mul_i)) << pre_i;
  // >= keeps the divider sane if the setting shrinks mid-count
  assign last   = div_q >= (factor - DIV_W'(1));
  assign tick_o = run_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          div_q <= '0;
    else if (!run_i)      div_q <= '0;
    else if (last)        div_q <= '0;
    else                  div_q <= div_q + DIV_W'(1);
  end

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && factor != DIV_W'(1) && $stable(factor)) |=> !tick_o); // R2
endmodule

// File: rtl/dtt_counter.sv
module dtt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] mod_shd_i,
  input  logic [CNT_W-1:0] dly_shd_i,
  input  logic             arm_set_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] mod_act_o,
  output logic [CNT_W-1:0] dly_act_o,
  output logic             arm_pend_o,
  output logic             match_o
);
  logic wrap;
  assign wrap    = tick_i && (cnt_o == mod_act_o);
  assign match_o = tick_i && (cnt_o == dly_act_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o      <= '0;
      mod_act_o  <= '0;
      dly_act_o  <= '0;
      arm_pend_o <= 1'b0;
    end else if (!run_i) begin
      // stopped: shadows pass straight through
      cnt_o      <= '0;
      mod_act_o  <= mod_shd_i;
      dly_act_o  <= dly_shd_i;
      arm_pend_o <= 1'b0;
    end else begin
      if (tick_i) cnt_o <= wrap ? '0 : cnt_o + CNT_W'(1);
      if (wrap && arm_pend_o) begin
        mod_act_o <= mod_shd_i;
        dly_act_o <= dly_shd_i;
      end
      arm_pend_o <= (arm_pend_o && !wrap) || arm_set_i;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= mod_act_o); // R3
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && cnt_o != mod_act_o) |=> cnt_o == $past(cnt_o) + CNT_W'(1)); // R3
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(cnt_o)); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_o == '0); // R11
  AST_ARM_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && arm_pend_o && wrap && !arm_set_i) |=> !arm_pend_o); // R10
  AST_FAR_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_act_o > mod_act_o) |-> !match_o); // R5
endmodule

// File: rtl/dtt_request.sv
module dtt_request (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic req_en_i,
  input  logic dma_mode_i,
  input  logic flag_clr_i,
  output logic irq_o,
  output logic dma_req_o
);
  logic fire;
  assign fire = match_i && req_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      dma_req_o <= 1'b0;
    end else begin
      dma_req_o <= fire && dma_mode_i;
      irq_o     <= (irq_o && !flag_clr_i) || (fire && !dma_mode_i);
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !flag_clr_i) |=> irq_o); // R8
  AST_DMA_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_mode_i && !irq_o) |=> !irq_o); // R7
  AST_QUIET_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_en_i && !irq_o) |=> (!irq_o && !dma_req_o)); // R6
endmodule

// File: rtl/dly_trig_timer.sv
module dly_trig_timer
  import dtt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              dma_req_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] mod_shd, dly_shd, mod_act, dly_act, cnt;
  logic             arm_set, flag_clr, arm_pend, tick, match;

  dtt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i,
    .mod_act_i(mod_act), .dly_act_i(dly_act), .cnt_i(cnt),
    .arm_pend_i(arm_pend), .flag_i(irq_o),
    .ctrl_o(ctrl), .mod_shd_o(mod_shd), .dly_shd_o(dly_shd),
    .arm_set_o(arm_set), .flag_clr_o(flag_clr), .rd_data_o
  );

  dtt_divider u_div (
    .clk_i, .rst_ni, .run_i(ctrl.run), .pre_i(ctrl.pre), .mul_i(ctrl.mul),
    .tick_o(tick)
  );

  dtt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .run_i(ctrl.run), .tick_i(tick),
    .mod_shd_i(mod_shd), .dly_shd_i(dly_shd), .arm_set_i(arm_set),
    .cnt_o(cnt), .mod_act_o(mod_act), .dly_act_o(dly_act),
    .arm_pend_o(arm_pend), .match_o(match)
  );

  dtt_request u_req (
    .clk_i, .rst_ni, .match_i(match), .req_en_i(ctrl.req_en),
    .dma_mode_i(ctrl.dma_mode), .flag_clr_i(flag_clr),
    .irq_o, .dma_req_o
  );
endmodule

// File: tb/sim_dly_trig_timer.sv
module sim_dly_trig_timer;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        irq, dma;

  int total = 0, bad = 0, cyc = 0, seen = 0;
  int exp_q[$];

  always #(CLK_PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dly_trig_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_o(irq), .dma_req_o(dma)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // monitor: pops one expected cycle per observed DMA pulse
  always @(negedge clk) begin
    if (rst_n && dma) begin
      seen++;
      if (exp_q.size() == 0) check("R4 unexpected pulse", cyc, -1);
      else check("R3/R4/R7 pulse cycle", cyc, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [1:0] a, input int d, output int at);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; at = cyc;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    rd_addr = a; #1; d = rd_data;
  endtask

  function automatic int ctl(int run, int pre, int mul, int ren, int dmam, int arm, int clr);
    return run | (pre << 1) | (mul << 4) | (ren << 6) | (dmam << 7) | (arm << 8) | (clr << 9);
  endfunction

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // driver side of the scoreboard: returns last expected cycle
  task automatic sched(input int w, input int f, input int d, input int m, input int n, output int last);
    for (int k = 0; k < n; k++) begin
      last = w + f*(d+1) + k*f*(m+1);
      exp_q.push_back(last);
    end
  endtask

  task automatic div_case(input int pre, input int mul, input int m, input int d, input int f);
    int w, last, t;
    wr(2'd1, m, t); wr(2'd2, d, t);
    wr(2'd0, ctl(1, pre, mul, 1, 1, 0, 0), w);
    sched(w, f, d, m, 2, last);
    wait_to(last);
    wr(2'd0, 0, t);
    check("R2 all divided pulses seen", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, w, t, last, s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); check("R1 reg zero", v, 0);
    end
    check("R1 irq low", irq, 0);
    check("R1 dma low", dma, 0);

    // R11: stopped, writes take effect at once
    wr(2'd1, 4, t); wr(2'd2, 0, t);
    rd(2'd1, v); check("R11 period immediate", v, 4);
    rd(2'd3, v); check("R11 count held zero", v, 0);

    // DMA mode, F=1, M=4, D=0
    wr(2'd0, ctl(1, 0, 0, 1, 1, 0, 0), w);
    sched(w, 1, 0, 4, 3, last);
    wait_to(w + 3);
    rd(2'd3, v); check("R3 count after three ticks", v, 3);
    wait_to(last);
    wr(2'd0, 0, t);
    check("R3 queue drained", exp_q.size(), 0);
    check("R7 flag untouched in dma mode", irq, 0);

    // R9/R10 shadow transfer on wrap
    wr(2'd0, ctl(1, 0, 0, 1, 1, 0, 0), w);
    exp_q.push_back(w + 1);
    wr(2'd2, 2, t);
    rd(2'd2, v); check("R9 pending delay hidden", v, 0);
    wr(2'd0, ctl(1, 0, 0, 1, 1, 1, 0), t);
    rd(2'd0, v); check("R10 arm pending", (v >> 8) & 1, 1);
    exp_q.push_back(w + 8);
    exp_q.push_back(w + 13);
    wait_to(w + 5);
    rd(2'd2, v); check("R10 delay in force after wrap", v, 2);
    rd(2'd0, v); check("R10 arm cleared", (v >> 8) & 1, 0);
    wait_to(w + 13);
    wr(2'd0, 0, t);
    check("R10 queue drained", exp_q.size(), 0);

    // R5 delay beyond period
    wr(2'd2, 7, t);
    s0 = seen;
    wr(2'd0, ctl(1, 0, 0, 1, 1, 0, 0), w);
    wait_to(w + 20);
    wr(2'd0, 0, t);
    check("R5 no pulse", seen - s0, 0);

    // R6 requests disabled
    wr(2'd1, 2, t); wr(2'd2, 1, t);
    s0 = seen;
    wr(2'd0, ctl(1, 0, 0, 0, 0, 0, 0), w);
    wait_to(w + 15);
    check("R6 no flag", irq, 0);
    wr(2'd0, ctl(1, 0, 0, 0, 1, 0, 0), t);
    wait_to(t + 12);
    wr(2'd0, 0, t);
    check("R6 no pulse", seen - s0, 0);

    // R8 sticky flag, F=1, M=3, D=1
    wr(2'd1, 3, t); wr(2'd2, 1, t);
    wr(2'd0, ctl(1, 0, 0, 1, 0, 0, 0), w);
    check("R4 flag not before match", irq, 0);
    wait_to(w + 2);
    check("R4 flag at delay match", irq, 1);
    wr(2'd0, ctl(0, 0, 0, 1, 0, 0, 0), t);
    @(negedge clk);
    check("R8 flag sticky after stop", irq, 1);
    rd(2'd0, v); check("R8 flag readable", (v >> 9) & 1, 1);
    wr(2'd0, ctl(0, 0, 0, 1, 0, 0, 1), t);
    check("R8 write-one clears", irq, 0);

    // R2 divider factors
    div_case(1, 1, 1, 1, 20);
    div_case(0, 2, 0, 0, 20);
    div_case(0, 3, 0, 0, 40);
    div_case(3, 0, 2, 0, 8);

    repeat (3) @(negedge clk);
    check("R7 no stray pulses", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule